// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial output and runs on its own internal data clock. When a request arrives, the controller pulls chip-select and read/convert low to start a conversion. It returns read/convert high after a fixed number of cycles, while the converter is still busy. It then watches the busy line until the conversion finishes.

Each convert edge makes the converter send back the result of the conversion before it. The converter produces 16 pulses on its own data clock to do this. The controller brings the data clock and data line into the system clock with two-flop synchronisers and samples a bit on each rising edge it detects. When all 16 bits are in and busy has returned high, it recodes the word into the output format that has been configured and presents it with a one-cycle strobe. The strobe carries two flags: one gives the number format, and the other marks a word that belongs to no real conversion.

The controller enforces a minimum acquisition interval between conversions. It issues no conversion while power-down is requested. It raises a timeout error when a conversion does not complete in time.

Top module: `adcrd_top`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_rc` are high, and `res_valid` and `err_timeout` are low.
- R2: A request that is accepted drives `adc_rc` low for exactly RC_LOW_CYC cycles. `adc_cs_n` is low whenever `adc_rc` is low, and it stays low after `adc_rc` returns high.
- R3: `adc_rc` is high at every rising edge of `adc_busy_n`, so the converter never starts a conversion by itself.
- R4: The word is built from 16 bits sampled on the rising edges of `adc_dclk`, MSB first. Each result is the word the converter transmits during that convert cycle, which is the sample taken by the conversion before it.
- R5: `adc_fmt` follows `cfg_straight` while the controller is idle and is frozen during a conversion (1 = straight binary, 0 = two's complement). `res_data` is given in two's complement when `out_twos`=1 and in straight binary when `out_twos`=0. The two formats differ only in an inverted MSB, and the result does not depend on `adc_fmt`. `res_twos` reports the output format.
- R6: `res_valid` is a single-cycle pulse. It is given only after 16 bits have been captured and `adc_busy_n` has returned high.
- R7: While `pd_req` is high, `adc_rc` does not fall. `adc_pwrd` follows `pd_req` one cycle later.
- R8: `res_stale` is 1 on the first result after reset and on the first result after power-down is requested. It is 0 on every other result.
- R9: At least ACQ_CYC cycles pass between a rising edge of `adc_busy_n` and the next falling edge of `adc_rc`.
- R10: If a conversion does not see `adc_busy_n` return high with 16 bits captured within TMO_CYC cycles of its start, `err_timeout` pulses for one cycle and no `res_valid` is given. The controller then accepts requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a conversion (level; accepted when idle) |
| pd_req | input | 1 | Power-down request; blocks conversions |
| cfg_straight | input | 1 | Converter format: 1 straight binary, 0 two's complement |
| out_twos | input | 1 | Output format: 1 two's complement, 0 straight binary |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rc | output | 1 | Read/convert; falling edge starts a conversion |
| adc_fmt | output | 1 | Format-select level driven to the converter |
| adc_pwrd | output | 1 | Power-down level driven to the converter |
| adc_busy_n | input | 1 | Converter busy, low during conversion |
| adc_dclk | input | 1 | Data clock generated by the converter |
| adc_data | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 16 | Received word in the output format |
| res_twos | output | 1 | 1 if res_data is two's complement |
| res_stale | output | 1 | Result belongs to no valid conversion |
| err_timeout | output | 1 | One-cycle conversion timeout pulse |

## Verification
If the bit counter or the capture edge slips, the fault shows in the very next result: the word is shifted or has the wrong value, and the scoreboard compares every result against the converter model's previous sample. A sequencer stuck in the wrong state shows at the converter pins within one conversion. The read/convert pulse would have the wrong width, read/convert would be low at a busy rise, or the acquisition gap would be too short. A lost stale or format flag shows on the first result after reset, after a power-down, or after a format change.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RUN,
        ST_ACQ
    } seq_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              twos;
        logic              stale;
    } result_t;

    // Straight binary and two's complement differ only in the MSB.
    function automatic logic [WORD_W-1:0] recode(
        input logic [WORD_W-1:0] raw,
        input logic              raw_straight,
        input logic              want_twos
    );
        logic [WORD_W-1:0] v;
        v = raw;
        if (raw_straight == want_twos)
            v[WORD_W-1] = ~raw[WORD_W-1];
        return v;
    endfunction

endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift
    import adcrd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         dclk_s,
    input  logic         data_s,
    output logic [W-1:0] word,
    output logic         full
);

    localparam int CW = $clog2(W + 1);

    logic          dclk_d;
    logic [CW-1:0] cnt;
    logic          edge_up;

    assign edge_up = dclk_s && !dclk_d;
    assign full    = (cnt == CW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_d <= 1'b0;
            cnt    <= '0;
            word   <= '0;
        end else begin
            dclk_d <= dclk_s;
            if (clr) begin
                cnt <= '0;
            end else if (edge_up && !full) begin
                word <= {word[W-2:0], data_s};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    AST_FULL_FREEZES: assert property (@(posedge clk) disable iff (rst) (full && !clr) |=> $stable(word)); // R4

endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
    import adcrd_pkg::*;
#(
    parameter int RC_LOW_CYC = 4,
    parameter int ACQ_CYC    = 20,
    parameter int TMO_CYC    = 400
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_req,
    input  logic    pd_req,
    input  logic    busy_s,
    input  logic    bits_full,
    output seq_st_t st,
    output logic    cs_n,
    output logic    rc,
    output logic    cap_clr,
    output logic    done,
    output logic    tmo
);

    localparam int CNT_MAX = (TMO_CYC > ACQ_CYC) ? TMO_CYC : ACQ_CYC;
    localparam int TW      = $clog2(CNT_MAX + 1);
    localparam int AW      = $clog2(ACQ_CYC + 1);

    logic [TW-1:0] tmr;
    logic          busy_d;
    logic          seen_low;
    logic          busy_rise;
    logic [AW-1:0] gap_cnt;

    assign busy_rise = busy_s && !busy_d;
    assign cs_n      = (st == ST_IDLE) || (st == ST_ACQ);
    assign rc        = (st != ST_HOLD);
    assign cap_clr   = (st == ST_IDLE) && start_req && !pd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            busy_d   <= 1'b1;
            seen_low <= 1'b0;
            done     <= 1'b0;
            tmo      <= 1'b0;
        end else begin
            busy_d <= busy_s;
            done   <= 1'b0;
            tmo    <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cap_clr) begin
                        st       <= ST_HOLD;
                        tmr      <= '0;
                        seen_low <= 1'b0;
                    end
                end
                ST_HOLD: begin
                    tmr <= tmr + 1'b1;
                    if (!busy_s) seen_low <= 1'b1;
                    if (tmr == TW'(RC_LOW_CYC - 1)) st <= ST_RUN;
                end
                ST_RUN: begin
                    tmr <= tmr + 1'b1;
                    if (!busy_s) seen_low <= 1'b1;
                    if (seen_low && busy_s && bits_full) begin
                        done <= 1'b1;
                        st   <= ST_ACQ;
                        tmr  <= '0;
                    end else if (tmr == TW'(TMO_CYC - 1)) begin
                        tmo <= 1'b1;
                        st  <= ST_ACQ;
                        tmr <= '0;
                    end
                end
                default: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TW'(ACQ_CYC - 1)) st <= ST_IDLE;
                end
            endcase
        end
    end

    // Independent count of cycles since busy last rose, for the gap check.
    always_ff @(posedge clk) begin
        if (rst)                          gap_cnt <= AW'(ACQ_CYC);
        else if (busy_rise)               gap_cnt <= '0;
        else if (gap_cnt != AW'(ACQ_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end

    AST_RC_HIGH_AT_BUSY: assert property (@(posedge clk) disable iff (rst) busy_rise |-> rc); // R3
    AST_ACQ_GAP: assert property (@(posedge clk) disable iff (rst) cap_clr |-> (gap_cnt >= AW'(ACQ_CYC))); // R9

endmodule

// File: rtl/adcrd_top.sv
module adcrd_top
    import adcrd_pkg::*;
#(
    parameter int RC_LOW_CYC = 4,
    parameter int ACQ_CYC    = 20,
    parameter int TMO_CYC    = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              pd_req,
    input  logic              cfg_straight,
    input  logic              out_twos,
    output logic              adc_cs_n,
    output logic              adc_rc,
    output logic              adc_fmt,
    output logic              adc_pwrd,
    input  logic              adc_busy_n,
    input  logic              adc_dclk,
    input  logic              adc_data,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data,
    output logic              res_twos,
    output logic              res_stale,
    output logic              err_timeout
);

    logic [2:0]        pins_raw;
    logic [2:0]        pins_s;
    seq_st_t           st;
    logic              cap_clr;
    logic              seq_done;
    logic              seq_tmo;
    logic [WORD_W-1:0] cap_word;
    logic              cap_full;
    logic              twos_lat;
    logic              stale_r;
    result_t           res_q;

    assign pins_raw = {adc_busy_n, adc_dclk, adc_data};

    adcrd_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    adcrd_seq #(
        .RC_LOW_CYC (RC_LOW_CYC),
        .ACQ_CYC    (ACQ_CYC),
        .TMO_CYC    (TMO_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .pd_req    (pd_req),
        .busy_s    (pins_s[2]),
        .bits_full (cap_full),
        .st        (st),
        .cs_n      (adc_cs_n),
        .rc        (adc_rc),
        .cap_clr   (cap_clr),
        .done      (seq_done),
        .tmo       (seq_tmo)
    );

    adcrd_shift #(.W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (cap_clr),
        .dclk_s (pins_s[1]),
        .data_s (pins_s[0]),
        .word   (cap_word),
        .full   (cap_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_fmt     <= 1'b1;
            twos_lat    <= 1'b0;
            stale_r     <= 1'b1;
            adc_pwrd    <= 1'b0;
            res_valid   <= 1'b0;
            err_timeout <= 1'b0;
            res_q       <= '0;
        end else begin
            adc_pwrd    <= pd_req;
            res_valid   <= seq_done;
            err_timeout <= seq_tmo;
            if (st == ST_IDLE) begin
                adc_fmt  <= cfg_straight;
                twos_lat <= out_twos;
            end
            if (pd_req)        stale_r <= 1'b1;
            else if (seq_done) stale_r <= 1'b0;
            if (seq_done) begin
                res_q.word  <= recode(cap_word, adc_fmt, twos_lat);
                res_q.twos  <= twos_lat;
                res_q.stale <= stale_r;
            end
        end
    end

    assign res_data  = res_q.word;
    assign res_twos  = res_q.twos;
    assign res_stale = res_q.stale;

    AST_RC_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) !adc_rc |-> !adc_cs_n); // R2
    AST_PD_KEEPS_RC: assert property (@(posedge clk) disable iff (rst) (pd_req && adc_rc) |=> adc_rc); // R7
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid); // R6
    AST_VALID_NOT_TMO: assert property (@(posedge clk) disable iff (rst) !(res_valid && err_timeout)); // R10

endmodule

// File: tb/tb_adcrd_top.sv
module tb_adcrd_top;

    localparam int CLK_PERIOD = 10;
    localparam int RC_LOW_CYC = 4;
    localparam int ACQ_CYC    = 20;
    localparam int TMO_CYC    = 400;
    localparam int BUSY_T     = 110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        pd_req = 1'b0;
    logic        cfg_straight = 1'b1;
    logic        out_twos = 1'b0;
    logic        adc_cs_n, adc_rc, adc_fmt, adc_pwrd;
    logic        adc_busy_n = 1'b1;
    logic        adc_dclk = 1'b0;
    logic        adc_data = 1'b0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        res_twos, res_stale, err_timeout;

    int n_chk = 0;
    int n_err = 0;

    typedef struct packed {
        logic [15:0] d;
        logic        st;
        logic        tw;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adcrd_top #(
        .RC_LOW_CYC (RC_LOW_CYC),
        .ACQ_CYC    (ACQ_CYC),
        .TMO_CYC    (TMO_CYC)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .pd_req       (pd_req),
        .cfg_straight (cfg_straight),
        .out_twos     (out_twos),
        .adc_cs_n     (adc_cs_n),
        .adc_rc       (adc_rc),
        .adc_fmt      (adc_fmt),
        .adc_pwrd     (adc_pwrd),
        .adc_busy_n   (adc_busy_n),
        .adc_dclk     (adc_dclk),
        .adc_data     (adc_data),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_twos     (res_twos),
        .res_stale    (res_stale),
        .err_timeout  (err_timeout)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Converter model: holds its last sample in straight binary.
    logic [15:0] held = 16'h1234;
    logic [15:0] analog_in = 16'h0000;
    logic [15:0] tx;
    bit          m_drop = 1'b0;
    bit          m_on = 1'b0;
    bit          rc_prev = 1'b1;
    bit          had_rise = 1'b0;
    int          m_t, np, k, ph;
    int          cyc = 0;
    int          rise_cyc = 0;
    int          rc_low_len = 0;
    int          rc_falls = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            m_on = 1'b0; adc_busy_n = 1'b1; adc_dclk = 1'b0; adc_data = 1'b0;
            rc_prev = 1'b1; had_rise = 1'b0; rc_low_len = 0;
        end else begin
            if (!adc_rc) rc_low_len++;
            if (rc_prev && !adc_rc) begin
                rc_falls++;
                chk(!adc_cs_n, "R2 cs low at rc fall", 32'(adc_cs_n), 32'd0);
                if (had_rise)
                    chk((cyc - rise_cyc) >= ACQ_CYC, "R9 acquisition gap", 32'(cyc - rise_cyc), 32'(ACQ_CYC));
                if (!m_on && !pd_req) begin
                    m_on = 1'b1; m_t = 0; adc_busy_n = 1'b0;
                    np = m_drop ? 12 : 16;
                    tx = adc_fmt ? held : (held ^ 16'h8000);
                end
            end
            if (!rc_prev && adc_rc) begin
                chk(rc_low_len == RC_LOW_CYC, "R2 rc low width", 32'(rc_low_len), 32'(RC_LOW_CYC));
                rc_low_len = 0;
            end
            if (m_on) begin
                m_t++;
                if (m_t >= 1 && m_t <= 6*np) begin
                    k = (m_t - 1) / 6;
                    ph = (m_t - 1) % 6;
                    if (ph == 0) begin adc_dclk = 1'b0; adc_data = tx[15-k]; end
                    else if (ph == 3) adc_dclk = 1'b1;
                end else if (m_t == 6*np + 1) begin
                    adc_dclk = 1'b0;
                end
                if (m_t == BUSY_T) begin
                    chk(adc_rc || adc_cs_n, "R3 control high at busy rise", 32'(adc_rc), 32'd1);
                    adc_busy_n = 1'b1; held = analog_in; m_on = 1'b0;
                    had_rise = 1'b1; rise_cyc = cyc;
                end
            end
            rc_prev = adc_rc;
        end
    end

    // Monitor: pops expected results as the design produces them.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            chk(adc_busy_n, "R6 valid only after busy high", 32'(adc_busy_n), 32'd1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected result", 32'(res_data), 32'hFFFFFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_data == e.d, "R4/R5 result word", 32'(res_data), 32'(e.d));
                chk(res_stale == e.st, "R8 stale flag", 32'(res_stale), 32'(e.st));
                chk(res_twos == e.tw, "R5 format flag", 32'(res_twos), 32'(e.tw));
            end
        end
    end

    logic [15:0] tb_last = 16'h1234;
    bit          exp_stale = 1'b1;

    task automatic do_conv(input logic [15:0] smp, input bit drop);
        bit got_v, got_e;
        int n;
        analog_in = smp;
        m_drop = drop;
        if (!drop) begin
            exp_q.push_back('{d: out_twos ? (tb_last ^ 16'h8000) : tb_last, st: exp_stale, tw: out_twos});
            exp_stale = 1'b0;
        end
        tb_last = smp;
        start_req = 1'b1;
        n = 0;
        while (adc_rc && n < 1000) begin @(negedge clk); n++; end
        start_req = 1'b0;
        chk(adc_fmt == cfg_straight, "R5 format pin", 32'(adc_fmt), 32'(cfg_straight));
        n = 0;
        got_v = 1'b0; got_e = 1'b0;
        while (!got_v && !got_e && n < 1000) begin
            @(negedge clk);
            got_v = res_valid; got_e = err_timeout; n++;
        end
        if (drop) begin
            chk(got_e && !got_v, "R10 timeout flagged without result", {30'd0, got_e, got_v}, 32'd2);
        end else begin
            chk(got_v && !got_e, "R6 result delivered", {30'd0, got_e, got_v}, 32'd1);
        end
        @(negedge clk);
        chk(!res_valid && !err_timeout, "R6 strobe lasts one cycle", {30'd0, err_timeout, res_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int falls0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n && adc_rc, "R1 idle control lines", {30'd0, adc_cs_n, adc_rc}, 32'd3);
        chk(!res_valid, "R1 no result after reset", 32'(res_valid), 32'd0);
        chk(!err_timeout, "R1 no error after reset", 32'(err_timeout), 32'd0);

        cfg_straight = 1'b1; out_twos = 1'b0;
        do_conv(16'hA1B2, 1'b0);
        do_conv(16'h0000, 1'b0);
        out_twos = 1'b1;
        do_conv(16'hFFFF, 1'b0);
        cfg_straight = 1'b0;
        do_conv(16'h8000, 1'b0);
        out_twos = 1'b0;
        do_conv(16'h5555, 1'b0);
        do_conv(16'h1357, 1'b1);
        do_conv(16'h2468, 1'b0);

        repeat (ACQ_CYC + 5) @(negedge clk);
        pd_req = 1'b1;
        start_req = 1'b1;
        falls0 = rc_falls;
        repeat (60) @(negedge clk);
        chk(rc_falls == falls0, "R7 no convert in power-down", 32'(rc_falls - falls0), 32'd0);
        chk(adc_pwrd, "R7 power-down pin", 32'(adc_pwrd), 32'd1);
        start_req = 1'b0;
        pd_req = 1'b0;
        exp_stale = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!adc_pwrd, "R7 power-down pin released", 32'(adc_pwrd), 32'd0);

        cfg_straight = 1'b1; out_twos = 1'b1;
        do_conv(16'h0F0F, 1'b0);
        do_conv(16'h1111, 1'b0);

        repeat (ACQ_CYC + 5) @(negedge clk);
        chk(adc_cs_n && adc_rc, "R1 idle again", {30'd0, adc_cs_n, adc_rc}, 32'd3);
        chk(exp_q.size() == 0, "R4 all results seen", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule